// File: doc/BRIEF.md
# Indexed CD Data Controller Register File

This block is the host-facing register set of a CD-ROM data controller. The host selects a 5-bit register index, then reads or writes one byte at a time. After every access the index moves on by one, so a burst of accesses walks through consecutive registers. The same index selects different registers for reads and for writes. Several accesses act on the block as well as moving data: a write to index 15 performs a soft reset, a read of the last status register acknowledges the decoder interrupt, and writes at the transfer-start and transfer-acknowledge positions drive the interface status flags.

The sector decoder and the transfer engine are outside this block. The decoder presents a one-cycle strobe together with two 4-byte header sets. The transfer engine receives a one-cycle start pulse and returns a one-cycle completion strobe. Interface status flags are active-low. A single level interrupt output merges the decoder and transfer-end sources, and an external enable input gates it.

Top module: `cd_regfile`

## Requirements
- R1: After the synchronous reset `rst_n` low, or after a host write while the index is 15: interface status reads 0xFF, interface control, both control registers and the status registers at indexes 12–14 are cleared, the status at index 15 reads 0x80, header set 0 reads 00 00 00 01, header set 1 reads all zeros, and the index is 0. A soft reset keeps the byte count, data address, write address and block pointer.
- R2: `idx_wr_en` loads the index from `idx_wr_data` and suppresses any access in that cycle. A write (`reg_wr_en`) or a read (`reg_rd_en`, ignored while `reg_wr_en` is high) increments the index by one, modulo 32. The single exception is the soft-reset write (R1).
- R3: At indexes 0 and 16–31 a read returns 0xFF and a write changes no register.
- R4: Writes to indexes 2/3, 4/5, 8/9 and 12/13 set the low/high bytes of the byte count, data address, write address and block pointer. Only bits 3:0 of a byte-count high write are stored. Reads at 2/3 return the byte count, at 8/9 the block pointer and at 10/11 the write address (low byte first).
- R5: A write to index 1 (interface control: bit 6 transfer-end interrupt enable, bit 5 decoder interrupt enable, bit 1 data output enable) with bit 1 clear sets status bits 3 (busy, active-low) and 1 (data ready, active-low) to 1.
- R6: A write to index 6 with data output enabled clears status bits 3 and 1, clears byte count bits 15:12, and raises `xfer_start` for exactly one cycle, in the following cycle. With data output disabled the write has no effect.
- R7: A write to index 7 sets status bit 6 (transfer-end pending, active-low) to 1 and clears byte count bits 15:12.
- R8: Status at index 14 is recomputed on writes to index 10 or 11. If control-0 bit 4 is set, it equals control-1 AND 0x08; otherwise it equals control-1 AND 0x0C.
- R9: A write to index 10 with bit 7 (decode enable) clear sets status bit 5 (decoder pending, active-low) to 1.
- R10: A read at index 15 returns the status value, then sets it to 0x80 and sets status bit 5 to 1. Index 13 always reads 0x00.
- R11: Control-1 bit 0 selects header set 0 or header set 1 for reads at indexes 4–7 (byte 0 first).
- R12: A `dec_strobe` while control-0 bit 7 is set loads the header sets from `dec_head0` and `dec_head1` (bits 31:24 are byte 0), sets index 15 status to 0x00 and index 12 status to 0x80, and clears status bit 5. If control-0 bit 2 is also set, `BLOCK_BYTES` is added to both the write address and the block pointer. With decode disabled the strobe is ignored.
- R13: An `xfer_done` strobe sets the byte count to 0xFFFF, sets status bits 3 and 1 to 1, and clears status bit 6.
- R14: `irq` is high exactly when `lvl5_en` is high and either the transfer-end enable is set with status bit 6 at 0, or the decoder enable is set with status bit 5 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| idx_wr_en | input | 1 | Load the register index |
| idx_wr_data | input | 5 | New index value |
| reg_wr_en | input | 1 | Host write at the current index |
| reg_rd_en | input | 1 | Host read at the current index |
| reg_wdata | input | 8 | Host write data |
| rd_data | output | 8 | Read data at the current index (combinational) |
| cur_idx | output | 5 | Current register index |
| dec_strobe | input | 1 | Decoder finished a sector |
| dec_head0 | input | 32 | Header set 0 from the decoder |
| dec_head1 | input | 32 | Header set 1 from the decoder |
| xfer_done | input | 1 | Transfer engine finished |
| lvl5_en | input | 1 | External interrupt enable |
| irq | output | 1 | Merged interrupt request level |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| byte_count | output | 16 | Byte count to the transfer engine |
| data_addr | output | 16 | Data address to the transfer engine |
| dec_enable | output | 1 | Control-0 decode enable |
| buf_wr_enable | output | 1 | Control-0 buffer write enable |

## Verification
The assertions assume that the engine strobes (`dec_strobe`, `xfer_done`) never arrive in the same cycle as a host access touching the same flags. The acknowledge and soft-reset checks exclude those collisions in their antecedents. They also assume that an index load and a register access are not requested together. The stimulus issues exactly one operation per cycle: an index load, a write, a read, a decoder strobe, a completion strobe or an idle cycle. Engine strobes are never overlapped with host traffic, so every expected value follows from a single, ordered event stream.

// File: rtl/cdreg_pkg.sv
// Shared constants for the indexed CD controller register file.
// Assumes an 8-bit host data path and a 5-bit register index.
package cdreg_pkg;
    localparam int IDX_W = 5;
    localparam int DW    = 8;
    localparam int CNT_W = 16;
    localparam int NREG  = 16;

    // interface control enable bit positions
    localparam int EN_XEND = 6;
    localparam int EN_DEC  = 5;
    localparam int EN_OUT  = 1;

    // control-0 bit positions
    localparam int C0_DECODE = 7;
    localparam int C0_AUTOFM = 4;
    localparam int C0_BUFWR  = 2;

    // control-1 bit positions
    localparam int C1_MODE = 3;
    localparam int C1_FORM = 2;
    localparam int C1_HSEL = 0;

    // write-side register positions
    localparam int W_IFC   = 1;
    localparam int W_CNTL  = 2;
    localparam int W_CNTH  = 3;
    localparam int W_ADRL  = 4;
    localparam int W_ADRH  = 5;
    localparam int W_START = 6;
    localparam int W_ACK   = 7;
    localparam int W_WAL   = 8;
    localparam int W_WAH   = 9;
    localparam int W_CTL0  = 10;
    localparam int W_CTL1  = 11;
    localparam int W_PTL   = 12;
    localparam int W_PTH   = 13;
    localparam int W_SRST  = 15;

    localparam logic [DW-1:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/cdreg_index.sv
// Register index counter: loads on request, clears on soft reset,
// otherwise steps by one per access and wraps at its natural width.
// Assumes at most one of load, clear and step is meaningful per cycle; load wins.
module cdreg_index #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         zero_en,
    input  logic         step_en,
    output logic [W-1:0] idx
);
    // index state update
    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (load_en) idx <= load_val;
        else if (zero_en) idx <= '0;
        else if (step_en) idx <= idx + W'(1);
    end
endmodule

// File: rtl/cdreg_word.sv
// Byte-lane writable counter register. Priority: load, lane write, add.
// The top lane stores only the bits set in HI_KEEP.
// Assumes W is a multiple of 8.
module cdreg_word #(
    parameter int           W       = 16,
    parameter logic [7:0]   HI_KEEP = 8'hFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W/8-1:0]     wr_lane,
    input  logic [7:0]         wr_data,
    input  logic               set_en,
    input  logic [W-1:0]       set_val,
    input  logic               add_en,
    input  logic [W-1:0]       add_val,
    output logic [W-1:0]       q
);
    localparam int LANES = W / 8;
    logic [W-1:0] sum;

    // next value for the accumulate path
    always_comb sum = q + add_val;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [7:0] KEEP = (g == LANES - 1) ? HI_KEEP : 8'hFF;
        // per-lane update
        always_ff @(posedge clk) begin
            if (!rst_n)          q[g*8 +: 8] <= 8'h00;
            else if (set_en)     q[g*8 +: 8] <= set_val[g*8 +: 8];
            else if (wr_lane[g]) q[g*8 +: 8] <= wr_data & KEEP;
            else if (add_en)     q[g*8 +: 8] <= sum[g*8 +: 8];
        end
    end
endmodule

// File: rtl/cdreg_irq.sv
// Interrupt merge: one level from two active-low pending flags, each
// qualified by its enable, then gated by the external enable.
module cdreg_irq (
    input  logic lvl_en,
    input  logic xend_en,
    input  logic xend_n,
    input  logic dec_en,
    input  logic dec_n,
    output logic irq
);
    // merged request level
    always_comb irq = lvl_en & ((xend_en & ~xend_n) | (dec_en & ~dec_n));
endmodule

// File: rtl/cd_regfile.sv
// Indexed CD controller register file. The host sets an index, then each
// read or write touches the register at that index and advances it.
// The read and write maps differ. Status flags are active-low.
// Assumes engine strobes are single-cycle and are not issued together with
// host accesses to the same flags; when they coincide, the engine wins.
module cd_regfile
    import cdreg_pkg::*;
#(
    parameter int BLOCK_BYTES = 2352
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr_en,
    input  logic [IDX_W-1:0] idx_wr_data,
    input  logic             reg_wr_en,
    input  logic             reg_rd_en,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    rd_data,
    output logic [IDX_W-1:0] cur_idx,
    input  logic             dec_strobe,
    input  logic [31:0]      dec_head0,
    input  logic [31:0]      dec_head1,
    input  logic             xfer_done,
    input  logic             lvl5_en,
    output logic             irq,
    output logic             xfer_start,
    output logic [CNT_W-1:0] byte_count,
    output logic [CNT_W-1:0] data_addr,
    output logic             dec_enable,
    output logic             buf_wr_enable
);
    localparam logic [CNT_W-1:0] BLK_STEP = CNT_W'(BLOCK_BYTES);
    localparam int HB = 4;

    logic             wr_hit, rd_hit, soft_rst, dec_take, start_ok;
    logic [NREG-1:0]  wr_at;
    logic [IDX_W-1:0] idx_q;

    // interface status flags (active-low)
    logic xend_n, decp_n, busy_n, rdy_n;
    // interface control enables
    logic en_xend, en_dec, en_out;
    // control registers (only bits with a function are kept)
    logic c0_decode, c0_autofm, c0_bufwr;
    logic c1_mode, c1_form, c1_hsel;
    // decoder status
    logic       crc_ok;
    logic [1:0] mode_form;
    logic       valid_n;
    logic [DW-1:0] hdr_q [2][HB];
    logic [DW-1:0] ifstat_byte;

    logic [CNT_W-1:0] wa_q, pt_q, cnt_set_val;
    logic             cnt_set;

    // host access qualification
    always_comb begin
        wr_hit   = reg_wr_en & ~idx_wr_en;
        rd_hit   = reg_rd_en & ~idx_wr_en & ~reg_wr_en;
        dec_take = dec_strobe & c0_decode;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_wsel
        assign wr_at[g] = wr_hit && (idx_q == IDX_W'(g));
    end

    assign soft_rst = wr_at[W_SRST];
    assign start_ok = wr_at[W_START] & en_out;

    cdreg_index #(.W(IDX_W)) i_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (idx_wr_en),
        .load_val (idx_wr_data),
        .zero_en  (soft_rst),
        .step_en  (wr_hit | rd_hit),
        .idx      (idx_q)
    );

    // byte count reload sources: completion, start and acknowledge
    always_comb begin
        cnt_set     = xfer_done | start_ok | wr_at[W_ACK];
        cnt_set_val = xfer_done ? {CNT_W{1'b1}} : {4'h0, byte_count[CNT_W-5:0]};
    end

    cdreg_word #(.W(CNT_W), .HI_KEEP(8'h0F)) i_count (
        .clk(clk), .rst_n(rst_n),
        .wr_lane({wr_at[W_CNTH], wr_at[W_CNTL]}), .wr_data(reg_wdata),
        .set_en(cnt_set), .set_val(cnt_set_val),
        .add_en(1'b0), .add_val('0),
        .q(byte_count)
    );

    cdreg_word #(.W(CNT_W), .HI_KEEP(8'hFF)) i_daddr (
        .clk(clk), .rst_n(rst_n),
        .wr_lane({wr_at[W_ADRH], wr_at[W_ADRL]}), .wr_data(reg_wdata),
        .set_en(1'b0), .set_val('0),
        .add_en(1'b0), .add_val('0),
        .q(data_addr)
    );

    cdreg_word #(.W(CNT_W), .HI_KEEP(8'hFF)) i_waddr (
        .clk(clk), .rst_n(rst_n),
        .wr_lane({wr_at[W_WAH], wr_at[W_WAL]}), .wr_data(reg_wdata),
        .set_en(1'b0), .set_val('0),
        .add_en(dec_take & c0_bufwr), .add_val(BLK_STEP),
        .q(wa_q)
    );

    cdreg_word #(.W(CNT_W), .HI_KEEP(8'hFF)) i_bptr (
        .clk(clk), .rst_n(rst_n),
        .wr_lane({wr_at[W_PTH], wr_at[W_PTL]}), .wr_data(reg_wdata),
        .set_en(1'b0), .set_val('0),
        .add_en(dec_take & c0_bufwr), .add_val(BLK_STEP),
        .q(pt_q)
    );

    // control, status and flag registers; engine strobes applied last
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            {xend_n, decp_n, busy_n, rdy_n} <= 4'b1111;
            {en_xend, en_dec, en_out}       <= 3'b000;
            {c0_decode, c0_autofm, c0_bufwr} <= 3'b000;
            {c1_mode, c1_form, c1_hsel}     <= 3'b000;
            crc_ok    <= 1'b0;
            mode_form <= 2'b00;
            valid_n   <= 1'b1;
            for (int s = 0; s < 2; s++)
                for (int b = 0; b < HB; b++)
                    hdr_q[s][b] <= (s == 0 && b == HB - 1) ? 8'h01 : 8'h00;
        end else begin
            if (wr_at[W_IFC]) begin
                en_xend <= reg_wdata[EN_XEND];
                en_dec  <= reg_wdata[EN_DEC];
                en_out  <= reg_wdata[EN_OUT];
                if (!reg_wdata[EN_OUT]) begin
                    busy_n <= 1'b1;
                    rdy_n  <= 1'b1;
                end
            end
            if (start_ok) begin
                busy_n <= 1'b0;
                rdy_n  <= 1'b0;
            end
            if (wr_at[W_ACK]) xend_n <= 1'b1;
            if (wr_at[W_CTL0]) begin
                c0_decode <= reg_wdata[C0_DECODE];
                c0_autofm <= reg_wdata[C0_AUTOFM];
                c0_bufwr  <= reg_wdata[C0_BUFWR];
                if (!reg_wdata[C0_DECODE]) decp_n <= 1'b1;
                mode_form <= {c1_mode, c1_form & ~reg_wdata[C0_AUTOFM]};
            end
            if (wr_at[W_CTL1]) begin
                c1_mode <= reg_wdata[C1_MODE];
                c1_form <= reg_wdata[C1_FORM];
                c1_hsel <= reg_wdata[C1_HSEL];
                mode_form <= {reg_wdata[C1_MODE], reg_wdata[C1_FORM] & ~c0_autofm};
            end
            if (rd_hit && idx_q == IDX_W'(15)) begin
                valid_n <= 1'b1;
                decp_n  <= 1'b1;
            end
            if (dec_take) begin
                for (int b = 0; b < HB; b++) begin
                    hdr_q[0][b] <= dec_head0[31-8*b -: 8];
                    hdr_q[1][b] <= dec_head1[31-8*b -: 8];
                end
                valid_n <= 1'b0;
                crc_ok  <= 1'b1;
                decp_n  <= 1'b0;
            end
            if (xfer_done) begin
                busy_n <= 1'b1;
                rdy_n  <= 1'b1;
                xend_n <= 1'b0;
            end
        end
    end

    // transfer start pulse, one cycle after an accepted start write
    always_ff @(posedge clk) begin
        if (!rst_n) xfer_start <= 1'b0;
        else        xfer_start <= start_ok;
    end

    // assembled interface status byte; unused bits read as 1
    always_comb ifstat_byte = {1'b1, xend_n, decp_n, 1'b1, busy_n, 1'b1, rdy_n, 1'b1};

    // read-side register map
    always_comb begin
        unique case (idx_q)
            5'd1:  rd_data = ifstat_byte;
            5'd2:  rd_data = byte_count[7:0];
            5'd3:  rd_data = byte_count[15:8];
            5'd4, 5'd5, 5'd6, 5'd7:
                   rd_data = hdr_q[c1_hsel][idx_q[1:0]];
            5'd8:  rd_data = pt_q[7:0];
            5'd9:  rd_data = pt_q[15:8];
            5'd10: rd_data = wa_q[7:0];
            5'd11: rd_data = wa_q[15:8];
            5'd12: rd_data = {crc_ok, 7'h00};
            5'd13: rd_data = 8'h00;
            5'd14: rd_data = {4'h0, mode_form, 2'b00};
            5'd15: rd_data = {valid_n, 7'h00};
            default: rd_data = IDLE_BYTE;
        endcase
    end

    cdreg_irq i_irq (
        .lvl_en  (lvl5_en),
        .xend_en (en_xend),
        .xend_n  (xend_n),
        .dec_en  (en_dec),
        .dec_n   (decp_n),
        .irq     (irq)
    );

    assign cur_idx       = idx_q;
    assign dec_enable    = c0_decode;
    assign buf_wr_enable = c0_bufwr;
endmodule

// File: rtl/cd_regfile_chk.sv
// Property checker for cd_regfile, attached with bind below.
// Assumes engine strobes do not collide with the host accesses named in each antecedent.
module cd_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        idx_wr_en,
    input logic        reg_wr_en,
    input logic        reg_rd_en,
    input logic [4:0]  cur_idx,
    input logic [7:0]  rd_data,
    input logic        dec_strobe,
    input logic        xfer_done,
    input logic        lvl5_en,
    input logic        irq,
    input logic        xfer_start,
    input logic [15:0] byte_count,
    input logic [7:0]  ifstat
);
    logic acc, wr_q, rd_q;
    assign wr_q = reg_wr_en & ~idx_wr_en;
    assign rd_q = reg_rd_en & ~idx_wr_en & ~reg_wr_en;
    assign acc  = wr_q | rd_q;

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !(wr_q && cur_idx == 5'd15) |=> cur_idx == 5'($past(cur_idx) + 5'd1)); // R2
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q && cur_idx == 5'd15 |=> cur_idx == 5'd0 && ifstat == 8'hFF); // R1
    AST_IDLE_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_idx == 5'd0 || cur_idx[4]) |-> rd_data == 8'hFF); // R3
    AST_STAT1_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cur_idx == 5'd13 |-> rd_data == 8'h00); // R10
    AST_STAT3_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q && cur_idx == 5'd15 && !dec_strobe |=> ifstat[5]); // R10
    AST_CNT_HI_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q && cur_idx == 5'd3 && !xfer_done |=> byte_count[15:12] == 4'h0); // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q && cur_idx == 5'd7 && !xfer_done |=> ifstat[6] && byte_count[15:12] == 4'h0); // R7
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start); // R6
    AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> byte_count == 16'hFFFF && !ifstat[6] && ifstat[3] && ifstat[1]); // R13
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl5_en |-> !irq); // R14
endmodule

bind cd_regfile cd_regfile_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_wr_en  (idx_wr_en),
    .reg_wr_en  (reg_wr_en),
    .reg_rd_en  (reg_rd_en),
    .cur_idx    (cur_idx),
    .rd_data    (rd_data),
    .dec_strobe (dec_strobe),
    .xfer_done  (xfer_done),
    .lvl5_en    (lvl5_en),
    .irq        (irq),
    .xfer_start (xfer_start),
    .byte_count (byte_count),
    .ifstat     (ifstat_byte)
);

// File: tb/test_cd_regfile.sv
// Bench: a behavioural reference model is compared against the design
// every clock, plus directed checks tagged by requirement.
module test_cd_regfile;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, idx_wr_en, reg_wr_en, reg_rd_en, dec_strobe, xfer_done, lvl5_en;
    logic [4:0]  idx_wr_data;
    logic [7:0]  reg_wdata;
    logic [31:0] dec_head0, dec_head1;
    logic [7:0]  rd_data;
    logic [4:0]  cur_idx;
    logic        irq, xfer_start, dec_enable, buf_wr_enable;
    logic [15:0] byte_count, data_addr;

    cd_regfile i_cd_regfile (.*);

    int n_chk = 0, n_err = 0;
    bit done = 0;
    logic [7:0] last_rd;

    // reference model state
    int m_idx, m_ifs, m_ifc, m_dbc, m_dac, m_wa, m_pt, m_c0, m_c1, m_s0, m_s2, m_s3;
    int m_h0[4], m_h1[4];
    bit m_start;

    localparam int OP_IDLE = 0, OP_IDX = 1, OP_WR = 2, OP_RD = 3, OP_DEC = 4, OP_DONE = 5;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic m_soft();
        m_ifs = 'hFF; m_ifc = 0; m_c0 = 0; m_c1 = 0; m_s0 = 0; m_s2 = 0; m_s3 = 'h80;
        m_h0 = '{0, 0, 0, 1}; m_h1 = '{0, 0, 0, 0}; m_idx = 0;
    endtask

    function automatic int m_read(int i);
        int h[4];
        h = (m_c1 & 1) ? m_h1 : m_h0;
        case (i)
            1: return m_ifs;
            2: return m_dbc & 'hFF;
            3: return (m_dbc >> 8) & 'hFF;
            4, 5, 6, 7: return h[i - 4];
            8: return m_pt & 'hFF;
            9: return (m_pt >> 8) & 'hFF;
            10: return m_wa & 'hFF;
            11: return (m_wa >> 8) & 'hFF;
            12: return m_s0;
            13: return 0;
            14: return m_s2;
            15: return m_s3;
            default: return 'hFF;
        endcase
    endfunction

    function automatic int m_irq();
        bit a, b;
        a = ((m_ifc & 'h40) != 0) && ((m_ifs & 'h40) == 0);
        b = ((m_ifc & 'h20) != 0) && ((m_ifs & 'h20) == 0);
        return (lvl5_en && (a || b)) ? 1 : 0;
    endfunction

    task automatic m_apply(input int kind, input int d);
        int old = m_idx;
        m_start = 0;
        case (kind)
            OP_IDX: m_idx = d & 31;
            OP_WR: begin
                m_idx = (old + 1) % 32;
                case (old)
                    1: begin if ((d & 2) == 0) m_ifs |= 'h0A; m_ifc = d; end
                    2: m_dbc = (m_dbc & 'hFF00) | d;
                    3: m_dbc = (m_dbc & 'hFF) | ((d & 'hF) << 8);
                    4: m_dac = (m_dac & 'hFF00) | d;
                    5: m_dac = (m_dac & 'hFF) | (d << 8);
                    6: if (m_ifc & 2) begin m_ifs &= ~'h0A; m_dbc &= 'h0FFF; m_start = 1; end
                    7: begin m_ifs |= 'h40; m_dbc &= 'h0FFF; end
                    8: m_wa = (m_wa & 'hFF00) | d;
                    9: m_wa = (m_wa & 'hFF) | (d << 8);
                    10: begin
                        if ((d & 'h80) == 0) m_ifs |= 'h20;
                        m_s2 = (d & 'h10) ? (m_c1 & 'h08) : (m_c1 & 'h0C);
                        m_c0 = d;
                    end
                    11: begin m_s2 = (m_c0 & 'h10) ? (d & 'h08) : (d & 'h0C); m_c1 = d; end
                    12: m_pt = (m_pt & 'hFF00) | d;
                    13: m_pt = (m_pt & 'hFF) | (d << 8);
                    15: m_soft();
                    default: ;
                endcase
            end
            OP_RD: begin
                m_idx = (old + 1) % 32;
                if (old == 15) begin m_s3 = 'h80; m_ifs |= 'h20; end
            end
            OP_DEC: if (m_c0 & 'h80) begin
                for (int b = 0; b < 4; b++) begin
                    m_h0[b] = (dec_head0 >> (24 - 8 * b)) & 'hFF;
                    m_h1[b] = (dec_head1 >> (24 - 8 * b)) & 'hFF;
                end
                m_s3 = 0; m_s0 = 'h80; m_ifs &= ~'h20;
                if (m_c0 & 'h04) begin
                    m_pt = (m_pt + 2352) & 'hFFFF;
                    m_wa = (m_wa + 2352) & 'hFFFF;
                end
            end
            OP_DONE: begin m_dbc = 'hFFFF; m_ifs |= 'h0A; m_ifs &= ~'h40; end
            default: ;
        endcase
        m_ifs &= 'hFF;
    endtask

    // one clock of stimulus, model update and comparison
    task automatic op(input int kind, input int d);
        idx_wr_en   = (kind == OP_IDX);
        idx_wr_data = d[4:0];
        reg_wr_en   = (kind == OP_WR);
        reg_rd_en   = (kind == OP_RD);
        reg_wdata   = d[7:0];
        dec_strobe  = (kind == OP_DEC);
        xfer_done   = (kind == OP_DONE);
        #1;
        chk("MODEL rd_data", rd_data, m_read(m_idx));
        last_rd = rd_data;
        @(posedge clk);
        @(negedge clk);
        m_apply(kind, d);
        {idx_wr_en, reg_wr_en, reg_rd_en, dec_strobe, xfer_done} = '0;
        chk("MODEL cur_idx", cur_idx, m_idx);
        chk("MODEL irq", irq, m_irq());
        chk("MODEL xfer_start", xfer_start, m_start);
        chk("MODEL byte_count", byte_count, m_dbc);
        chk("MODEL data_addr", data_addr, m_dac);
        chk("MODEL dec_enable", dec_enable, (m_c0 >> 7) & 1);
        chk("MODEL buf_wr_enable", buf_wr_enable, (m_c0 >> 2) & 1);
    endtask

    task automatic wr(input int i, input int d);
        op(OP_IDX, i);
        op(OP_WR, d);
    endtask

    task automatic rd(input int i, output int v);
        op(OP_IDX, i);
        op(OP_RD, 0);
        v = last_rd;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int v;
        rst_n = 0; lvl5_en = 1;
        {idx_wr_en, reg_wr_en, reg_rd_en, dec_strobe, xfer_done} = '0;
        idx_wr_data = 0; reg_wdata = 0; dec_head0 = 0; dec_head1 = 0;
        m_soft(); m_dbc = 0; m_dac = 0; m_wa = 0; m_pt = 0; m_start = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 index", cur_idx, 0);
        rd(1, v);  chk("R1 ifstat", v, 'hFF);
        rd(15, v); chk("R1 stat3", v, 'h80);
        rd(4, v);  chk("R1 head0", v, 0);
        rd(7, v);  chk("R1 head3", v, 1);

        // R2 index wrap and step
        op(OP_IDX, 31); op(OP_RD, 0); chk("R2 wrap", cur_idx, 0);
        op(OP_RD, 0); chk("R2 step", cur_idx, 1);

        // R3 idle positions
        rd(0, v);  chk("R3 idx0", v, 'hFF);
        rd(20, v); chk("R3 idx20", v, 'hFF);
        wr(0, 'h55); wr(20, 'h00);
        rd(1, v);  chk("R3 ifstat untouched", v, 'hFF);
        rd(2, v);  chk("R3 count untouched", v, 0);

        // R4 byte-wide counters
        wr(2, 'h34); wr(3, 'hAB);
        rd(2, v); chk("R4 count lo", v, 'h34);
        rd(3, v); chk("R4 count hi masked", v, 'h0B);
        chk("R4 byte_count", byte_count, 'h0B34);
        wr(4, 'hCD); wr(5, 'hEF);
        chk("R4 data_addr", data_addr, 'hEFCD);

        // R12 decoder strobe with buffer writes
        wr(10, 'h84); wr(12, 'h10); wr(13, 0); wr(8, 0); wr(9, 1);
        chk("R12 buf_wr_enable", buf_wr_enable, 1);
        dec_head0 = 32'h11223344; dec_head1 = 32'hAABBCCDD;
        op(OP_DEC, 0);
        rd(4, v); chk("R12 head0", v, 'h11);
        rd(7, v); chk("R12 head3", v, 'h44);
        rd(8, v); chk("R12 ptr lo", v, 'h40);
        rd(9, v); chk("R12 ptr hi", v, 'h09);
        rd(10, v); chk("R12 waddr lo", v, 'h30);
        rd(11, v); chk("R12 waddr hi", v, 'h0A);
        rd(12, v); chk("R12 stat0", v, 'h80);

        // R11 header set select
        wr(11, 'h01);
        rd(5, v); chk("R11 set1 byte1", v, 'hBB);
        rd(6, v); chk("R11 set1 byte2", v, 'hCC);
        wr(11, 'h00);
        rd(5, v); chk("R11 set0 byte1", v, 'h22);

        // R10 status acknowledge
        rd(15, v); chk("R10 stat3 valid", v, 'h00);
        chk("R10 index after", cur_idx, 16);
        rd(15, v); chk("R10 stat3 cleared", v, 'h80);
        rd(13, v); chk("R10 stat1", v, 0);

        // R14 interrupt merge
        wr(1, 'h20); chk("R14 idle", irq, 0);
        op(OP_DEC, 0); chk("R14 decoder", irq, 1);
        lvl5_en = 0; op(OP_IDLE, 0); chk("R14 gated", irq, 0);
        lvl5_en = 1; op(OP_IDLE, 0); chk("R14 ungated", irq, 1);
        rd(15, v); chk("R14 ack drops", irq, 0);

        // R9 decode disable
        op(OP_DEC, 0); chk("R9 pending", irq, 1);
        wr(10, 'h04); chk("R9 cleared", irq, 0);
        dec_head0 = 32'h55667788;
        op(OP_DEC, 0); chk("R9 strobe ignored irq", irq, 0);
        rd(4, v); chk("R9 strobe ignored head", v, 'h11);

        // R8 mode/form status
        wr(10, 'h10); wr(11, 'h0E);
        rd(14, v); chk("R8 auto", v, 'h08);
        wr(10, 'h00);
        rd(14, v); chk("R8 manual", v, 'h0C);
        wr(11, 'h00);

        // R6 transfer start
        wr(1, 'h00); wr(6, 0); chk("R6 disabled", xfer_start, 0);
        rd(1, v); chk("R6 disabled flags", v, 'hFF);
        wr(1, 'h42); wr(6, 0); chk("R6 pulse", xfer_start, 1);
        op(OP_IDLE, 0); chk("R6 pulse end", xfer_start, 0);
        rd(1, v); chk("R6 flags", v, 'hF5);

        // R13 transfer done
        op(OP_DONE, 0); chk("R13 count", byte_count, 'hFFFF);
        chk("R13 irq", irq, 1);
        rd(1, v); chk("R13 flags", v, 'hBF);

        // R7 acknowledge
        wr(7, 0); chk("R7 irq", irq, 0);
        chk("R7 count", byte_count, 'h0FFF);
        rd(1, v); chk("R7 flags", v, 'hFF);

        // R5 abort by clearing output enable
        wr(6, 0); rd(1, v); chk("R5 busy", v, 'hF5);
        wr(1, 'h40); rd(1, v); chk("R5 aborted", v, 'hFF);

        // R1 soft reset
        wr(10, 'h84); wr(11, 'h01);
        wr(15, 0); chk("R1 soft index", cur_idx, 0);
        chk("R1 soft ctrl0", dec_enable, 0);
        rd(15, v); chk("R1 soft stat3", v, 'h80);
        rd(7, v);  chk("R1 soft head", v, 1);
        chk("R1 soft keeps count", byte_count, 'h0FFF);
        chk("R1 soft keeps addr", data_addr, 'hEFCD);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule